// File: doc/BRIEF.md
# Byte/Word Banked Data Memory Port

This block is a unified 16-bit memory made of two byte-wide banks that share one row decoder. It serves two requesters. An instruction-fetch port always receives a whole 16-bit word. A data port takes a byte-resolved address and can access either a full word or a single byte. Storage is organised as words. The low bit of every byte address is kept out of the row decode and is used only afterwards: on a byte read it picks which byte is returned, and on a byte write it picks which bank is written.

Both ports share one single-ported row of the two banks, so only one access can happen per cycle. When both ports ask in the same cycle, fetch wins. The data port sees a combinational stall that cycle, and its request is dropped, so the requester has to present it again. Reads are synchronous and their results appear one cycle after the request. A word access at an odd byte address raises a one-cycle misalignment flag and is still performed on the word that contains that address.

Top module: `bmp_mem_port`

## Requirements
- R1: A granted data word read at byte address A returns {high bank, low bank} of row A>>1 on `data_rdata` with `data_rvalid` high in the cycle after the request.
- R2: A fetch at byte address A returns the full 16-bit word of row A>>1 on `fetch_rdata` with `fetch_rvalid` high in the cycle after the request.
- R3: A data byte read reads the whole row. Address bit 0 equal to 0 returns the low byte (word bits 7:0), and 1 returns the high byte (bits 15:8). The byte is placed in `data_rdata[7:0]` and bits 15:8 are zero.
- R4: A data byte write stores `data_wdata[7:0]` in the bank chosen by address bit 0 (0 low, 1 high). The other byte of that row and `data_wdata[15:8]` have no effect.
- R5: A data word write stores `data_wdata[7:0]` in the low bank and `data_wdata[15:8]` in the high bank of row A>>1. A write produces no `data_rvalid`.
- R6: A data word access (read or write) at an odd byte address raises `data_misalign` for exactly the cycle after the request, and the access is performed on row A>>1.
- R7: A fetch at an odd byte address raises `fetch_misalign` for the cycle after the request and still returns the full word of row A>>1.
- R8: When `fetch_req` and `data_req` are both high, fetch is served and `data_stall` is high in that same cycle. The data access is not performed: nothing is written and `data_rvalid` stays low.
- R9: During and right after reset, `fetch_rvalid`, `data_rvalid`, both misalignment flags, `fetch_rdata` and `data_rdata` are all low.
- R10: A data byte access never raises `data_misalign`, whatever the value of address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_rvalid | output | 1 | Fetch word valid, one cycle after request |
| fetch_rdata | output | 16 | Fetched word |
| fetch_misalign | output | 1 | Previous fetch used an odd address |
| data_req | input | 1 | Data access request |
| data_we | input | 1 | 1 write, 0 read |
| data_byte | input | 1 | 1 byte access, 0 word access |
| data_addr | input | ADDR_W | Data byte address |
| data_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| data_stall | output | 1 | Data request refused this cycle (fetch has priority) |
| data_rvalid | output | 1 | Data read result valid |
| data_rdata | output | 16 | Data read result; byte reads zero-extended |
| data_misalign | output | 1 | Previous data word access used an odd address |

## Verification
A wrong bank write enable corrupts the neighbouring byte of the same row. That error stays hidden until the row is read back, so every byte write in the bench is followed by a word read of the same row. A swapped lane select or a bad zero-extension shows on the very next byte read, one cycle after the request. An arbitration fault shows in the same cycle as `data_stall`. A write that slips through during a stall is caught by reading the row back after the conflict.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_FETCH = 2'd1,
    GNT_DATA  = 2'd2
  } grant_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;

  // Bank write enables from access kind and byte-address bit 0.
  function automatic logic [LANES-1:0] lane_wen(input logic we,
                                                input logic byte_mode,
                                                input logic lsb);
    logic [LANES-1:0] w;
    if (!we)            w = '0;
    else if (!byte_mode) w = '1;
    else if (lsb)       w = 2'b10;
    else                w = 2'b01;
    return w;
  endfunction

  // Shape a read word for the data bus.
  function automatic logic [WORD_W-1:0] steer(input logic [WORD_W-1:0] word,
                                              input logic byte_mode,
                                              input logic lsb);
    logic [WORD_W-1:0] r;
    if (!byte_mode)  r = word;
    else if (lsb)    r = {{LANE_W{1'b0}}, word[WORD_W-1:LANE_W]};
    else             r = {{LANE_W{1'b0}}, word[LANE_W-1:0]};
    return r;
  endfunction

  function automatic logic is_misaligned(input logic byte_mode, input logic lsb);
    return !byte_mode && lsb;
  endfunction

endpackage

// File: rtl/bmp_arbiter.sv
module bmp_arbiter
  import bmp_pkg::*;
(
  input  logic   fetch_req,
  input  logic   data_req,
  output grant_e grant,
  output logic   data_stall
);

  always_comb begin
    if (fetch_req)     grant = GNT_FETCH;
    else if (data_req) grant = GNT_DATA;
    else               grant = GNT_NONE;
  end

  assign data_stall = data_req && fetch_req;

endmodule

// File: rtl/bmp_addr_ctrl.sv
module bmp_addr_ctrl
  import bmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned ROW_W = ADDR_W - 1
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  grant_e                       grant,
  input  logic [ADDR_W-1:0]            fetch_addr,
  input  logic [ADDR_W-1:0]            data_addr,
  input  logic                         data_we,
  input  logic                         data_byte,
  input  logic [WORD_W-1:0]            data_wdata,
  output logic [ROW_W-1:0]             row,
  output logic                         bank_en,
  output logic [LANES-1:0]             bank_wen,
  output logic [LANES-1:0][LANE_W-1:0] bank_wdata,
  output logic                         ev_data_read,
  output logic                         ev_byte_sel,
  output logic                         ev_lsb,
  output logic                         ev_mis_data,
  output logic                         ev_mis_fetch
);

  logic is_data;
  logic is_fetch;

  assign is_data  = (grant == GNT_DATA);
  assign is_fetch = (grant == GNT_FETCH);

  // Row decode never looks at byte-address bit 0.
  assign row     = is_fetch ? fetch_addr[ADDR_W-1:1] : data_addr[ADDR_W-1:1];
  assign bank_en = is_data || is_fetch;

  assign bank_wen = is_data ? lane_wen(data_we, data_byte, data_addr[0]) : '0;

  // A byte write brings its data in on bits 7:0 for either lane.
  assign bank_wdata[0] = data_wdata[LANE_W-1:0];
  assign bank_wdata[1] = data_byte ? data_wdata[LANE_W-1:0]
                                   : data_wdata[WORD_W-1:LANE_W];

  assign ev_data_read = is_data && !data_we;
  assign ev_byte_sel  = data_byte;
  assign ev_lsb       = data_addr[0];
  assign ev_mis_data  = is_data && is_misaligned(data_byte, data_addr[0]);
  assign ev_mis_fetch = is_fetch && fetch_addr[0];

  AST_BYTE_WRITE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && data_we && data_byte) |-> ($countones(bank_wen) == 1)); // R4

  AST_WORD_WRITE_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && data_we && !data_byte) |-> (bank_wen == 2'b11)); // R5

  AST_FETCH_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |-> (bank_wen == '0)); // R8

endmodule

// File: rtl/bmp_bank.sv
module bmp_bank #(
  parameter int unsigned ROW_W  = 9,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DEPTH = 1 << ROW_W
)(
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end

endmodule

// File: rtl/bmp_rsp.sv
module bmp_rsp
  import bmp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  grant_e                       grant,
  input  logic                         ev_data_read,
  input  logic                         ev_byte_sel,
  input  logic                         ev_lsb,
  input  logic                         ev_mis_data,
  input  logic                         ev_mis_fetch,
  input  logic [LANES-1:0][LANE_W-1:0] bank_rdata,
  output logic                         fetch_rvalid,
  output logic [WORD_W-1:0]            fetch_rdata,
  output logic                         fetch_misalign,
  output logic                         data_rvalid,
  output logic [WORD_W-1:0]            data_rdata,
  output logic                         data_misalign
);

  logic              fetch_q;
  logic              dread_q;
  logic              byte_q;
  logic              lsb_q;
  logic [WORD_W-1:0] row_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q        <= 1'b0;
      dread_q        <= 1'b0;
      byte_q         <= 1'b0;
      lsb_q          <= 1'b0;
      data_misalign  <= 1'b0;
      fetch_misalign <= 1'b0;
    end else begin
      fetch_q        <= (grant == GNT_FETCH);
      dread_q        <= ev_data_read;
      byte_q         <= ev_byte_sel;
      lsb_q          <= ev_lsb;
      data_misalign  <= ev_mis_data;
      fetch_misalign <= ev_mis_fetch;
    end
  end

  assign row_word     = {bank_rdata[1], bank_rdata[0]};
  assign fetch_rvalid = fetch_q;
  assign data_rvalid  = dread_q;
  assign fetch_rdata  = fetch_q ? row_word : '0;
  assign data_rdata   = dread_q ? steer(row_word, byte_q, lsb_q) : '0;

  AST_ONE_RESPONSE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_rvalid && data_rvalid)); // R8

  AST_MISALIGN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_misalign && !$past(ev_mis_data)) |-> 1'b0); // R6

endmodule

// File: rtl/bmp_mem_port.sv
module bmp_mem_port
  import bmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned ROW_W = ADDR_W - 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_rvalid,
  output logic [15:0]       fetch_rdata,
  output logic              fetch_misalign,
  input  logic              data_req,
  input  logic              data_we,
  input  logic              data_byte,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [15:0]       data_wdata,
  output logic              data_stall,
  output logic              data_rvalid,
  output logic [15:0]       data_rdata,
  output logic              data_misalign
);

  grant_e                       grant;
  logic [ROW_W-1:0]             row;
  logic                         bank_en;
  logic [LANES-1:0]             bank_wen;
  logic [LANES-1:0][LANE_W-1:0] bank_wdata;
  logic [LANES-1:0][LANE_W-1:0] bank_rdata;
  logic                         ev_data_read;
  logic                         ev_byte_sel;
  logic                         ev_lsb;
  logic                         ev_mis_data;
  logic                         ev_mis_fetch;

  bmp_arbiter i_arb (
    .fetch_req  (fetch_req),
    .data_req   (data_req),
    .grant      (grant),
    .data_stall (data_stall)
  );

  bmp_addr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant        (grant),
    .fetch_addr   (fetch_addr),
    .data_addr    (data_addr),
    .data_we      (data_we),
    .data_byte    (data_byte),
    .data_wdata   (data_wdata),
    .row          (row),
    .bank_en      (bank_en),
    .bank_wen     (bank_wen),
    .bank_wdata   (bank_wdata),
    .ev_data_read (ev_data_read),
    .ev_byte_sel  (ev_byte_sel),
    .ev_lsb       (ev_lsb),
    .ev_mis_data  (ev_mis_data),
    .ev_mis_fetch (ev_mis_fetch)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bmp_bank #(.ROW_W(ROW_W), .LANE_W(LANE_W)) i_bank (
      .clk   (clk),
      .en    (bank_en),
      .we    (bank_wen[g]),
      .row   (row),
      .wdata (bank_wdata[g]),
      .rdata (bank_rdata[g])
    );
  end

  bmp_rsp i_rsp (
    .clk            (clk),
    .rst_n          (rst_n),
    .grant          (grant),
    .ev_data_read   (ev_data_read),
    .ev_byte_sel    (ev_byte_sel),
    .ev_lsb         (ev_lsb),
    .ev_mis_data    (ev_mis_data),
    .ev_mis_fetch   (ev_mis_fetch),
    .bank_rdata     (bank_rdata),
    .fetch_rvalid   (fetch_rvalid),
    .fetch_rdata    (fetch_rdata),
    .fetch_misalign (fetch_misalign),
    .data_rvalid    (data_rvalid),
    .data_rdata     (data_rdata),
    .data_misalign  (data_misalign)
  );

  AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> fetch_rvalid); // R2

  AST_WORD_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && !data_we && !fetch_req) |=> data_rvalid); // R1

  AST_STALL_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_stall |=> !data_rvalid); // R8

  AST_MISALIGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_misalign |-> $past(data_req && !data_byte && data_addr[0] && !fetch_req)); // R6

  AST_BYTE_NO_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && data_byte) |=> !data_misalign); // R10

  AST_BYTE_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && data_byte && !data_we && !fetch_req) |=> (data_rdata[15:8] == 8'h00)); // R3

  AST_FETCH_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_addr[0]) |=> fetch_misalign); // R7

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |-> (!fetch_rvalid && !data_rvalid && !data_misalign)); // R9

endmodule

// File: tb/test_bmp_mem_port.sv
module test_bmp_mem_port;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_rvalid;
  logic [15:0]   fetch_rdata;
  logic          fetch_misalign;
  logic          data_req = 1'b0;
  logic          data_we = 1'b0;
  logic          data_byte = 1'b0;
  logic [AW-1:0] data_addr = '0;
  logic [15:0]   data_wdata = '0;
  logic          data_stall;
  logic          data_rvalid;
  logic [15:0]   data_rdata;
  logic          data_misalign;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bmp_mem_port #(.ADDR_W(AW)) i_bmp_mem_port (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_rvalid(fetch_rvalid), .fetch_rdata(fetch_rdata),
    .fetch_misalign(fetch_misalign),
    .data_req(data_req), .data_we(data_we), .data_byte(data_byte),
    .data_addr(data_addr), .data_wdata(data_wdata),
    .data_stall(data_stall), .data_rvalid(data_rvalid),
    .data_rdata(data_rdata), .data_misalign(data_misalign)
  );

  // op: 0 word write, 1 byte write, 2 word read, 3 byte read, 4 fetch
  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [15:0]   wdata;
    logic [15:0]   exp;
    logic          mis;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 10'h010, 16'hA1B2, 16'h0000, 1'b0},
    '{3'd2, 10'h010, 16'h0000, 16'hA1B2, 1'b0},
    '{3'd3, 10'h010, 16'h0000, 16'h00B2, 1'b0},
    '{3'd3, 10'h011, 16'h0000, 16'h00A1, 1'b0},
    '{3'd1, 10'h011, 16'h0037, 16'h0000, 1'b0},
    '{3'd2, 10'h010, 16'h0000, 16'h37B2, 1'b0},
    '{3'd1, 10'h010, 16'h00C4, 16'h0000, 1'b0},
    '{3'd4, 10'h010, 16'h0000, 16'h37C4, 1'b0},
    '{3'd0, 10'h3FE, 16'h5566, 16'h0000, 1'b0},
    '{3'd4, 10'h3FE, 16'h0000, 16'h5566, 1'b0},
    '{3'd2, 10'h3FF, 16'h0000, 16'h5566, 1'b1},
    '{3'd0, 10'h021, 16'h1234, 16'h0000, 1'b1},
    '{3'd2, 10'h020, 16'h0000, 16'h1234, 1'b0},
    '{3'd1, 10'h3FF, 16'hFF99, 16'h0000, 1'b0},
    '{3'd3, 10'h3FF, 16'h0000, 16'h0099, 1'b0},
    '{3'd4, 10'h3FF, 16'h0000, 16'h9966, 1'b1},
    '{3'd3, 10'h3FE, 16'h0000, 16'h0066, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R5";
      3'd1: return "R4";
      3'd2: return "R1";
      3'd3: return "R3";
      default: return "R2";
    endcase
  endfunction

  // Called just after a falling edge; checks at the next falling edge.
  task automatic run_vec(input vec_t v);
    string t;
    t = tag_of(v.op);
    if (v.op == 3'd4) begin
      fetch_req = 1'b1; fetch_addr = v.addr;
    end else begin
      data_req  = 1'b1;
      data_we   = (v.op <= 3'd1);
      data_byte = (v.op == 3'd1) || (v.op == 3'd3);
      data_addr = v.addr;
      data_wdata = v.wdata;
    end
    @(negedge clk);
    if (v.op == 3'd4) begin
      check(fetch_rvalid == 1'b1, t, "fetch_rvalid", 16'(fetch_rvalid), 16'h1);
      check(fetch_rdata == v.exp, t, "fetch_rdata", fetch_rdata, v.exp);
      check(fetch_misalign == v.mis, "R7", "fetch_misalign",
            16'(fetch_misalign), 16'(v.mis));
    end else if (v.op >= 3'd2) begin
      check(data_rvalid == 1'b1, t, "data_rvalid", 16'(data_rvalid), 16'h1);
      check(data_rdata == v.exp, t, "data_rdata", data_rdata, v.exp);
    end else begin
      check(data_rvalid == 1'b0, "R5", "write rvalid", 16'(data_rvalid), 16'h0);
    end
    if (v.op != 3'd4) begin
      if (v.op == 3'd1 || v.op == 3'd3)
        check(data_misalign == 1'b0, "R10", "byte misalign",
              16'(data_misalign), 16'h0);
      else
        check(data_misalign == v.mis, "R6", "word misalign",
              16'(data_misalign), 16'(v.mis));
    end
    fetch_req = 1'b0; data_req = 1'b0; data_we = 1'b0; data_byte = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs quiet while in reset and just after release
    check(!fetch_rvalid && !data_rvalid && !fetch_misalign && !data_misalign,
          "R9", "flags in reset", 16'({fetch_rvalid, data_rvalid}), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_rdata == 16'h0 && data_rdata == 16'h0, "R9", "rdata after reset",
          fetch_rdata | data_rdata, 16'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: misalign lasts one cycle only
    @(negedge clk);
    check(data_misalign == 1'b0, "R6", "misalign pulse width",
          16'(data_misalign), 16'h0);

    // Seed row for the conflict test
    run_vec('{3'd0, 10'h040, 16'h0F0F, 16'h0000, 1'b0});

    // R8: simultaneous requests, fetch wins, data write dropped
    fetch_req = 1'b1; fetch_addr = 10'h010;
    data_req = 1'b1; data_we = 1'b1; data_byte = 1'b0;
    data_addr = 10'h040; data_wdata = 16'hDEAD;
    #1;
    check(data_stall == 1'b1, "R8", "data_stall on conflict", 16'(data_stall), 16'h1);
    @(negedge clk);
    check(fetch_rvalid && fetch_rdata == 16'h37C4, "R8", "fetch served",
          fetch_rdata, 16'h37C4);
    check(data_rvalid == 1'b0, "R8", "no data response", 16'(data_rvalid), 16'h0);
    fetch_req = 1'b0; data_req = 1'b0; data_we = 1'b0;

    // R8: stall low with data alone; stalled write left the row intact
    data_req = 1'b1; data_addr = 10'h040;
    #1;
    check(data_stall == 1'b0, "R8", "no stall without fetch", 16'(data_stall), 16'h0);
    data_req = 1'b0;
    run_vec('{3'd2, 10'h040, 16'h0000, 16'h0F0F, 1'b0});

    // R8: conflicting read gives no data response
    fetch_req = 1'b1; fetch_addr = 10'h3FE;
    data_req = 1'b1; data_addr = 10'h010;
    @(negedge clk);
    check(data_rvalid == 1'b0 && fetch_rdata == 16'h9966, "R8", "conflict read",
          fetch_rdata, 16'h9966);
    fetch_req = 1'b0; data_req = 1'b0;

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule